// File: doc/BRIEF.md
# I2C Register Target with Wrapping Pointer

This block is an I2C target that opens a bank of twenty byte-wide registers, numbered 01h to 14h, to a host on the bus. It answers one fixed 7-bit device address. A write transaction first loads an internal pointer from its first data byte. Each later data byte goes to the register the pointer names, and the pointer then steps on. A read transaction is a pointer write, then a repeated START with the read address, and the target returns bytes from the pointed register onward. In both directions the pointer steps from 14h back to 01h, not to 00h.

SCL and SDA arrive as asynchronous levels. They pass through a synchroniser and are oversampled by the system clock, so every bus event is seen as a sampled edge. The block drives SDA only through a pull-low enable, which suits an open-drain pad. Registers that software may write are held inside the block. The read-only registers are supplied by neighbouring logic through `rf_ro_data`. A one-cycle `rf_rd_pulse`, valid together with `rf_addr`, marks each byte that is loaded for transmission, so that status registers can clear themselves on read. A one-cycle `reg_wr_pulse` marks each byte committed to a writable register.

Top module: `i2c_regbank_target`

## Requirements
- R1: Only the device address 0100101b is acknowledged (write byte 4Ah, read byte 4Bh). Any other address, the general call address 00h included, leaves SDA released. After a mismatch the block ignores the bus until the next START.
- R2: The first data byte after a write-direction address loads the pointer. It produces no register write.
- R3: Each data byte after the pointer byte is written to the pointed register, and the pointer then advances. After 14h it goes to 01h. This repeats until a STOP or a repeated START.
- R4: Read-only addresses (03h, 04h and 0Ah to 0Fh by default) acknowledge written bytes. They keep their value and raise no `reg_wr_pulse`.
- R5: After a pointer write, a repeated START and the read address 4Bh, the block returns the pointed register MSB first. Read-only addresses return `rf_ro_data`. Writable addresses return the last value written to them.
- R6: A burst read advances the pointer after each byte and goes from 14h to 01h. A master NACK ends it: SDA stays released and no further byte is loaded.
- R7: The block holds SDA low for the whole high phase of the ninth clock after each byte it accepts. A register write commits while SCL is high in that ACK clock.
- R8: SDA falling while SCL is high is a START. SDA rising while SCL is high is a STOP. A repeated START restarts the address phase. The block changes `sda_pull` only while the sampled SCL is low.
- R9: `rf_rd_pulse` is high for exactly one clock per byte loaded for transmission, with `rf_addr` equal to that byte's register address.
- R10: Register 00h and addresses above 14h read as 00h. Writes to them are acknowledged but have no effect.
- R11: After reset SDA is released, both strobes are low, and every writable register reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock level from the pad |
| sda_in | input | 1 | Bus data level from the pad |
| sda_pull | output | 1 | High to pull SDA low (open-drain enable) |
| rf_addr | output | 8 | Current register pointer |
| rf_rd_pulse | output | 1 | One-cycle mark of a byte loaded for transmission |
| rf_ro_data | input | 8 | Value of the read-only register at `rf_addr` |
| reg_wr_pulse | output | 1 | One-cycle mark of a committed register write |
| reg_wr_data | output | 8 | Byte being committed |

## Verification
At the rising SCL edge of an ACK clock the block does two things in the same cycle: it commits a byte (or loads one for transmission), and it steps the pointer, including the step from 14h to 01h. The bench starts bursts at 13h in both directions so that the commit for 14h and the wrap fall in that shared cycle. It then checks the address and data on each strobe against a behavioural register model, and it reads the registers back to confirm that 01h received the byte after 14h. A second case is a repeated START arriving straight after an accepted data byte. The bench checks that the earlier write stands and that the next byte is taken as a fresh pointer.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_RX,
        ST_RACK,
        ST_TX,
        ST_TACK
    } rb_state_e;

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_cond,
    output logic stop_cond
);

    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.scl_pipe = {s_q.scl_pipe[STAGES-2:0], scl_raw};
        s_d.sda_pipe = {s_q.sda_pipe[STAGES-2:0], sda_raw};
        s_d.scl_prev = s_q.scl_pipe[STAGES-1];
        s_d.sda_prev = s_q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_lvl    = s_q.scl_pipe[STAGES-1];
    assign sda_lvl    = s_q.sda_pipe[STAGES-1];
    assign scl_rise   = scl_lvl & ~s_q.scl_prev;
    assign scl_fall   = ~scl_lvl & s_q.scl_prev;
    assign start_cond = scl_lvl & s_q.scl_prev & s_q.sda_prev & ~sda_lvl;
    assign stop_cond  = scl_lvl & s_q.scl_prev & ~s_q.sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_rb_regs.sv
module i2c_rb_regs
    import i2c_rb_pkg::*;
#(
    parameter int          REG_FIRST = 1,
    parameter int          REG_LAST  = 20,
    parameter logic [31:0] RO_MASK   = 32'h0000_FC18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] addr,
    input  logic              wr_req,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] ro_data,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              wr_accept
);

    localparam int NREG = REG_LAST + 1;

    logic [BYTE_W-1:0] cells [NREG];
    logic              wr_ok;

    for (genvar i = 0; i < NREG; i++) begin : g_cell
        if (i < REG_FIRST) begin : g_hole
            assign cells[i] = '0;
        end else if (RO_MASK[i]) begin : g_ro
            assign cells[i] = ro_data;
        end else begin : g_rw
            logic [BYTE_W-1:0] cell_d, cell_q;
            always_comb begin
                cell_d = cell_q;
                if (wr_accept && addr == BYTE_W'(i)) cell_d = wr_data;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cell_q <= '0;
                else        cell_q <= cell_d;
            end
            assign cells[i] = cell_q;
        end
    end

    always_comb begin
        rd_byte = '0;
        wr_ok   = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            if (addr == BYTE_W'(i)) begin
                rd_byte = cells[i];
                wr_ok   = (i >= REG_FIRST) && !RO_MASK[i];
            end
        end
    end

    assign wr_accept = wr_req & wr_ok;

endmodule

// File: rtl/i2c_rb_engine.sv
module i2c_rb_engine
    import i2c_rb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'b0100101,
    parameter int         REG_FIRST = 1,
    parameter int         REG_LAST  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_cond,
    input  logic              stop_cond,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_pull,
    output logic [BYTE_W-1:0] ptr,
    output logic              wr_req,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_load
);

    typedef struct packed {
        rb_state_e         st;
        logic [2:0]        cnt;
        logic [BYTE_W-1:0] sh;
        logic              pull;
        logic              rw;
        logic              sub;
        logic              ph;
        logic [BYTE_W-1:0] ptr;
    } eng_t;

    eng_t q, n;
    logic [BYTE_W-1:0] in_byte;

    function automatic logic [BYTE_W-1:0] adv(input logic [BYTE_W-1:0] p);
        if (p == BYTE_W'(REG_LAST)) return BYTE_W'(REG_FIRST);
        return p + BYTE_W'(1);
    endfunction

    assign in_byte = {q.sh[BYTE_W-2:0], sda_lvl};

    always_comb begin
        n       = q;
        wr_req  = 1'b0;
        rd_load = 1'b0;
        if (stop_cond) begin
            n.st   = ST_IDLE;
            n.pull = 1'b0;
        end else if (start_cond) begin
            n.st   = ST_ADDR;
            n.cnt  = '0;
            n.pull = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR: if (scl_rise) begin
                    n.sh  = in_byte;
                    n.cnt = q.cnt + 3'd1;
                    if (q.cnt == 3'd7) begin
                        if (in_byte[7:1] == DEV_ADDR) begin
                            n.st = ST_AACK;
                            n.rw = in_byte[0];
                            n.ph = 1'b0;
                        end else begin
                            n.st = ST_IDLE;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall && !q.ph) n.pull = 1'b1;
                    if (scl_rise) begin
                        n.ph = 1'b1;
                        if (q.rw) begin
                            rd_load = 1'b1;
                            n.sh    = rd_byte;
                            n.ptr   = adv(q.ptr);
                        end
                    end
                    if (scl_fall && q.ph) begin
                        n.cnt = '0;
                        n.ph  = 1'b0;
                        if (q.rw) begin
                            n.st   = ST_TX;
                            n.pull = ~q.sh[7];
                        end else begin
                            n.st   = ST_RX;
                            n.pull = 1'b0;
                            n.sub  = 1'b1;
                        end
                    end
                end
                ST_RX: if (scl_rise) begin
                    n.sh  = in_byte;
                    n.cnt = q.cnt + 3'd1;
                    if (q.cnt == 3'd7) begin
                        n.st = ST_RACK;
                        n.ph = 1'b0;
                    end
                end
                ST_RACK: begin
                    if (scl_fall && !q.ph) n.pull = 1'b1;
                    if (scl_rise) begin
                        n.ph = 1'b1;
                        if (q.sub) begin
                            n.ptr = q.sh;
                            n.sub = 1'b0;
                        end else begin
                            wr_req = 1'b1;
                            n.ptr  = adv(q.ptr);
                        end
                    end
                    if (scl_fall && q.ph) begin
                        n.st   = ST_RX;
                        n.pull = 1'b0;
                        n.cnt  = '0;
                        n.ph   = 1'b0;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        n.cnt = q.cnt + 3'd1;
                        if (q.cnt == 3'd7) n.ph = 1'b1;
                    end
                    if (scl_fall) begin
                        if (q.ph) begin
                            n.st   = ST_TACK;
                            n.pull = 1'b0;
                            n.ph   = 1'b0;
                        end else begin
                            n.sh   = {q.sh[BYTE_W-2:0], 1'b0};
                            n.pull = ~q.sh[6];
                        end
                    end
                end
                ST_TACK: begin
                    if (scl_rise) begin
                        if (!sda_lvl) begin
                            rd_load = 1'b1;
                            n.sh    = rd_byte;
                            n.ptr   = adv(q.ptr);
                            n.ph    = 1'b1;
                        end else begin
                            n.st = ST_IDLE;
                        end
                    end
                    if (scl_fall && q.ph) begin
                        n.st   = ST_TX;
                        n.pull = ~q.sh[7];
                        n.cnt  = '0;
                        n.ph   = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
        end else begin
            q <= n;
        end
    end

    assign sda_pull = q.pull;
    assign ptr      = q.ptr;
    assign wr_data  = q.sh;

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
    import i2c_rb_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR    = 7'b0100101,
    parameter int          REG_FIRST   = 1,
    parameter int          REG_LAST    = 20,
    parameter logic [31:0] RO_MASK     = 32'h0000_FC18,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_pull,
    output logic [7:0] rf_addr,
    output logic       rf_rd_pulse,
    input  logic [7:0] rf_ro_data,
    output logic       reg_wr_pulse,
    output logic [7:0] reg_wr_data
);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_cond, stop_cond;
    logic wr_req;
    logic [BYTE_W-1:0] rd_byte;

    i2c_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_raw    (scl_in),
        .sda_raw    (sda_in),
        .scl_lvl    (scl_lvl),
        .sda_lvl    (sda_lvl),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_cond (start_cond),
        .stop_cond  (stop_cond)
    );

    i2c_rb_engine #(
        .DEV_ADDR  (DEV_ADDR),
        .REG_FIRST (REG_FIRST),
        .REG_LAST  (REG_LAST)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_lvl    (sda_lvl),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_cond (start_cond),
        .stop_cond  (stop_cond),
        .rd_byte    (rd_byte),
        .sda_pull   (sda_pull),
        .ptr        (rf_addr),
        .wr_req     (wr_req),
        .wr_data    (reg_wr_data),
        .rd_load    (rf_rd_pulse)
    );

    i2c_rb_regs #(
        .REG_FIRST (REG_FIRST),
        .REG_LAST  (REG_LAST),
        .RO_MASK   (RO_MASK)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (rf_addr),
        .wr_req    (wr_req),
        .wr_data   (reg_wr_data),
        .ro_data   (rf_ro_data),
        .rd_byte   (rd_byte),
        .wr_accept (reg_wr_pulse)
    );

endmodule

// File: rtl/i2c_regbank_target_chk.sv
module i2c_regbank_target_chk #(
    parameter int          REG_FIRST = 1,
    parameter int          REG_LAST  = 20,
    parameter logic [31:0] RO_MASK   = 32'h0000_FC18
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       sda_pull,
    input logic [7:0] rf_addr,
    input logic       rf_rd_pulse,
    input logic       reg_wr_pulse
);

    // R8: the data output only moves while the sampled clock is low
    assert_sda_change_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> !scl_s);

    // R7: a commit happens inside the ACK high phase with SDA held low
    assert_wr_in_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_pulse |-> (scl_s && sda_pull));

    // R4 and R10: commits only reach writable, in-range registers
    assert_wr_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_pulse |-> (rf_addr >= 8'(REG_FIRST) && rf_addr <= 8'(REG_LAST)
                          && ((RO_MASK >> rf_addr) & 32'd1) == 32'd0));

    // R9: a load strobe lasts one cycle and never coincides with a commit
    assert_rd_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_pulse |=> !rf_rd_pulse);

    assert_rd_not_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_pulse |-> !reg_wr_pulse);

    // R3: a write to the last register moves the pointer to the first
    assert_wr_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_pulse && rf_addr == 8'(REG_LAST)) |=> rf_addr == 8'(REG_FIRST));

    // R6: a load of the last register moves the pointer to the first
    assert_rd_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_rd_pulse && rf_addr == 8'(REG_LAST)) |=> rf_addr == 8'(REG_FIRST));

endmodule

bind i2c_regbank_target i2c_regbank_target_chk #(
    .REG_FIRST (REG_FIRST),
    .REG_LAST  (REG_LAST),
    .RO_MASK   (RO_MASK)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_s        (scl_lvl),
    .sda_pull     (sda_pull),
    .rf_addr      (rf_addr),
    .rf_rd_pulse  (rf_rd_pulse),
    .reg_wr_pulse (reg_wr_pulse)
);

// File: tb/i2c_regbank_target_tb.sv
module i2c_regbank_target_tb;

    typedef logic [7:0] bq_t [$];

    localparam int Q = 6;
    localparam int H = 12;
    localparam logic [31:0] RO = 32'h0000_FC18;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_pull, rf_rd_pulse, reg_wr_pulse;
    logic [7:0] rf_addr, reg_wr_data, rf_ro_data;
    wire        sda_line = m_sda & ~sda_pull;

    assign rf_ro_data = rf_addr ^ 8'h5A;

    i2c_regbank_target u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (m_scl),
        .sda_in       (sda_line),
        .sda_pull     (sda_pull),
        .rf_addr      (rf_addr),
        .rf_rd_pulse  (rf_rd_pulse),
        .rf_ro_data   (rf_ro_data),
        .reg_wr_pulse (reg_wr_pulse),
        .reg_wr_data  (reg_wr_data)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [7:0] mregs [0:20];
    int mptr = 0;
    int ewa [$];
    int ewd [$];
    int era [$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit is_rw(input int a);
        return a >= 1 && a <= 20 && !RO[a];
    endfunction

    function automatic logic [7:0] exp_val(input int a);
        if (a == 0 || a > 20) return 8'h00;
        if (RO[a]) return 8'(a) ^ 8'h5A;
        return mregs[a];
    endfunction

    function automatic int nxt(input int a);
        return (a == 20) ? 1 : ((a + 1) & 255);
    endfunction

    // per-clock comparison of the strobes against the model's queues
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr_pulse) begin
                if (ewa.size() == 0) chk(1'b0, "R3 unexpected write", int'(rf_addr), -1);
                else begin
                    int a, d;
                    a = ewa.pop_front();
                    d = ewd.pop_front();
                    chk(int'(rf_addr) == a && int'(reg_wr_data) == d, "R3 write target",
                        int'({rf_addr, reg_wr_data}), (a << 8) | d);
                    chk(m_scl == 1'b1, "R7 commit in ack high", int'(m_scl), 1);
                end
            end
            if (rf_rd_pulse) begin
                if (era.size() == 0) chk(1'b0, "R9 unexpected load", int'(rf_addr), -1);
                else begin
                    int a;
                    a = era.pop_front();
                    chk(int'(rf_addr) == a, "R9 load address", int'(rf_addr), a);
                end
            end
        end
    end

    task automatic tick(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic e, l;
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q);
            m_scl = 1'b1; tick(H);
            m_scl = 1'b0; tick(1);
        end
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(1);
        e = sda_line; tick(H - 2);
        l = sda_line; tick(1);
        m_scl = 1'b0; tick(1);
        acked = !e && !l;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            m_scl = 1'b1; tick(H / 2);
            b[i] = sda_line; tick(H / 2);
            m_scl = 1'b0; tick(1);
        end
        m_sda = ~mack; tick(Q);
        m_scl = 1'b1; tick(H);
        m_scl = 1'b0; tick(1);
        m_sda = 1'b1;
    endtask

    task automatic wr_txn(input logic [7:0] sub, input bq_t data, input string req);
        logic ak;
        bus_start();
        send_byte(8'h4A, ak); chk(ak, "R1 address ack", int'(ak), 1);
        send_byte(sub, ak);   chk(ak, "R2 pointer ack", int'(ak), 1);
        mptr = int'(sub);
        foreach (data[k]) begin
            if (is_rw(mptr)) begin
                ewa.push_back(mptr);
                ewd.push_back(int'(data[k]));
                mregs[mptr] = data[k];
            end
            send_byte(data[k], ak);
            chk(ak, req, int'(ak), 1);
            mptr = nxt(mptr);
        end
        bus_stop();
    endtask

    task automatic rd_txn(input logic [7:0] sub, input int cnt, input string req);
        logic ak;
        logic [7:0] b;
        int a;
        bus_start();
        send_byte(8'h4A, ak); chk(ak, "R5 address ack", int'(ak), 1);
        send_byte(sub, ak);   chk(ak, "R5 pointer ack", int'(ak), 1);
        mptr = int'(sub);
        bus_start();
        a = mptr;
        for (int k = 0; k < cnt; k++) begin
            era.push_back(a);
            a = nxt(a);
        end
        send_byte(8'h4B, ak); chk(ak, "R5 read address ack", int'(ak), 1);
        for (int k = 0; k < cnt; k++) begin
            recv_byte(k < cnt - 1, b);
            chk(b == exp_val(mptr), req, int'(b), int'(exp_val(mptr)));
            mptr = nxt(mptr);
        end
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic ak;
        logic [7:0] b;
        bit held;
        for (int i = 0; i <= 20; i++) mregs[i] = 8'h00;
        tick(5);
        // R11: reset state
        chk(sda_pull == 1'b0 && rf_rd_pulse == 1'b0 && reg_wr_pulse == 1'b0, "R11 reset outputs",
            int'({sda_pull, rf_rd_pulse, reg_wr_pulse}), 0);
        rst_n = 1'b1;
        tick(5);
        rd_txn(8'h01, 2, "R11 writable reads zero");

        // R1: general call and a foreign address are ignored
        bus_start();
        send_byte(8'h00, ak); chk(!ak, "R1 general call", int'(ak), 0);
        send_byte(8'h4A, ak); chk(!ak, "R1 idle until START", int'(ak), 0);
        bus_stop();
        bus_start();
        send_byte(8'h4C, ak); chk(!ak, "R1 foreign address", int'(ak), 0);
        bus_stop();

        // R2 and R5: pointer load, then MSB-first readback of patterns
        wr_txn(8'h01, '{8'hA5, 8'h3C}, "R2 data ack");
        rd_txn(8'h01, 2, "R5 readback");
        wr_txn(8'h05, '{8'h81}, "R2 single write");
        rd_txn(8'h05, 1, "R5 msb first");

        // R3: burst write across 14h -> 01h
        wr_txn(8'h13, '{8'h13, 8'h14, 8'hC1, 8'hC2}, "R3 burst ack");
        rd_txn(8'h13, 4, "R3 wrap readback");

        // R6: burst read wrap from 12h
        rd_txn(8'h12, 5, "R6 burst read wrap");

        // R4: writes to read-only registers acked and dropped
        wr_txn(8'h03, '{8'hFF, 8'hEE, 8'h66}, "R4 read-only ack");
        rd_txn(8'h03, 3, "R4 read-only unchanged");
        rd_txn(8'h0A, 1, "R5 read-only source");

        // R10: 00h and out-of-range addresses
        wr_txn(8'h00, '{8'h77, 8'h44}, "R10 hole ack");
        rd_txn(8'h00, 2, "R10 hole reads zero");
        wr_txn(8'h16, '{8'h99}, "R10 high ack");
        rd_txn(8'h16, 1, "R10 high reads zero");

        // R8: repeated START right after a data byte restarts the address phase
        bus_start();
        send_byte(8'h4A, ak); chk(ak, "R8 address ack", int'(ak), 1);
        send_byte(8'h08, ak); chk(ak, "R8 pointer ack", int'(ak), 1);
        ewa.push_back(8); ewd.push_back(8'h11); mregs[8] = 8'h11;
        send_byte(8'h11, ak); chk(ak, "R8 data ack", int'(ak), 1);
        bus_start();
        send_byte(8'h4A, ak); chk(ak, "R8 restart ack", int'(ak), 1);
        send_byte(8'h10, ak); chk(ak, "R8 new pointer ack", int'(ak), 1);
        ewa.push_back(16); ewd.push_back(8'h22); mregs[16] = 8'h22;
        send_byte(8'h22, ak); chk(ak, "R8 data after restart", int'(ak), 1);
        bus_stop();
        rd_txn(8'h08, 2, "R8 first write kept");
        rd_txn(8'h10, 1, "R8 second write");

        // R8: bytes after STOP without a START are not answered
        send_byte(8'h4A, ak); chk(!ak, "R8 no start no ack", int'(ak), 0);
        bus_stop();

        // R6: master NACK ends the read; SDA stays released afterwards
        bus_start();
        send_byte(8'h4A, ak);
        send_byte(8'h02, ak);
        bus_start();
        era.push_back(2);
        send_byte(8'h4B, ak); chk(ak, "R6 read address ack", int'(ak), 1);
        recv_byte(1'b0, b);
        chk(b == exp_val(2), "R6 last byte", int'(b), int'(exp_val(2)));
        held = 1'b1;
        m_sda = 1'b1;
        for (int i = 0; i < 9; i++) begin
            tick(Q); m_scl = 1'b1; tick(H / 2);
            if (sda_line != 1'b1) held = 1'b0;
            tick(H / 2); m_scl = 1'b0; tick(1);
        end
        chk(held, "R6 released after NACK", int'(held), 1);
        bus_stop();

        tick(10);
        chk(ewa.size() == 0 && era.size() == 0, "R9 all strobes seen",
            ewa.size() + era.size(), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule